// File: doc/BRIEF.md
# Windowed Pixel-Memory Write Address Sequencer

This block generates the write address for a display memory that packs two 4-bit pixels into each byte. The memory is organised as 64 byte-columns by 80 rows, so each row holds 128 pixels. Before a burst of pixel bytes, software defines a rectangular window by loading a column range and a row range. Each pixel byte is then written at the current column/row position. After the write, the position steps to the next cell of the window.

Two scan orders exist. In row-major order the column runs first and the row steps each time the column leaves its range. In column-major order the row runs first and the column steps each time the row leaves its range. When an axis passes its end it returns to its programmed start, not to zero. The memory array and the command decoder that produces the load strobes sit outside this block.

Top module: `win_addr_seq`

## Requirements
- R1: After a synchronous active-high reset the window spans the whole memory (columns 0 to 63, rows 0 to 79), both pointers are 0 and no write is issued.
- R2: In the same cycle as `wr_stb`, `mem_we` is high, `mem_data` equals `wr_byte`, and `mem_addr` equals column + row × 64 for the current pointers. With `wr_stb` low, `mem_we` is low.
- R3: In row-major order (`vert_mode` = 0), a write whose column is below the column end increments the column and leaves the row unchanged from the next cycle on.
- R4: In row-major order, a write at or past the column end reloads the column start and steps the row.
- R5: In row-major order, when the row steps at or past the row end it reloads the row start.
- R6: In column-major order (`vert_mode` = 1), each write steps the row, and the row reloads the row start once it is at or past the row end.
- R7: In column-major order the column steps only when the row wraps, and it reloads the column start once it is at or past the column end.
- R8: A column load sets both the current column and the column start to `col_first` mod 64, and sets the column end to `col_last` mod 64.
- R9: A row load sets both the current row and the row start to `row_first` mod 80, and sets the row end to `row_last` mod 80.
- R10: With no write and no load, both pointers hold their values across any number of cycles.
- R11: A write in the same cycle as any window load is issued at the pre-load address and advances neither pointer. The load takes effect in the next cycle.
- R12: If a start lies beyond its end, every step of that axis reloads the start, so the axis stays at its start value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| col_load | input | 1 | Load the column window |
| col_first | input | 8 | Column start value (reduced mod 64) |
| col_last | input | 8 | Column end value (reduced mod 64) |
| row_load | input | 1 | Load the row window |
| row_first | input | 8 | Row start value (reduced mod 80) |
| row_last | input | 8 | Row end value (reduced mod 80) |
| vert_mode | input | 1 | 1 selects column-major order, 0 selects row-major order |
| wr_stb | input | 1 | A pixel byte is presented |
| wr_byte | input | 8 | Pixel byte (two 4-bit pixels) |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 13 | Memory byte address |
| mem_data | output | 8 | Memory write data |

## Verification
The bench builds the block with its default geometry: 64 byte-columns, 80 rows and 8-bit load values. At these values an 8-bit load can exceed both dimensions. This lets the tests drive the mod-64 and the non-power-of-two mod-80 folding with inputs such as 70, 165 and 200. The full geometry also places the last cell (column 63, row 79, address 5119) inside a small window. This exercises the wrap of both axes at the true memory edge, alongside reversed windows and loads that coincide with writes.

// File: rtl/win_addr_seq_pkg.sv
package win_addr_seq_pkg;

    // Scan order: which axis advances on every pixel byte
    typedef enum logic {
        SCAN_ROW_MAJOR = 1'b0,
        SCAN_COL_MAJOR = 1'b1
    } scan_e;

    // Fold an arbitrary load value into the range 0..n-1
    function automatic int unsigned fold_mod(input int unsigned v, input int unsigned n);
        return (n == 0) ? 0 : (v % n);
    endfunction

    // Pointer width for an axis of n positions
    function automatic int unsigned ptr_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/win_axis_ptr.sv
module win_axis_ptr
    import win_addr_seq_pkg::*;
#(
    parameter int unsigned N    = 64,
    parameter int unsigned IN_W = 8,
    localparam int unsigned AW  = ptr_width(N)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load_i,
    input  logic [IN_W-1:0] first_i,
    input  logic [IN_W-1:0] last_i,
    input  logic            step_i,
    output logic [AW-1:0]   cur_o,
    output logic            at_end_o
);

    typedef struct packed {
        logic [AW-1:0] cur;
        logic [AW-1:0] lo;
        logic [AW-1:0] hi;
    } axis_st_t;

    axis_st_t st_q, st_d;
    logic [AW-1:0] first_f, last_f;

    assign first_f = AW'(fold_mod(32'(first_i), N));
    assign last_f  = AW'(fold_mod(32'(last_i), N));

    // At or beyond the end: the next step reloads the start
    assign at_end_o = (st_q.cur >= st_q.hi);
    assign cur_o    = st_q.cur;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.cur = first_f;
            st_d.lo  = first_f;
            st_d.hi  = last_f;
        end else if (step_i) begin
            st_d.cur = at_end_o ? st_q.lo : st_q.cur + AW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.cur <= '0;
            st_q.lo  <= '0;
            st_q.hi  <= AW'(N - 1);
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/win_step_ctrl.sv
module win_step_ctrl
    import win_addr_seq_pkg::*;
(
    input  logic  wr_i,
    input  logic  hold_i,
    input  scan_e order_i,
    input  logic  col_end_i,
    input  logic  row_end_i,
    output logic  col_step_o,
    output logic  row_step_o
);

    logic adv;
    assign adv = wr_i & ~hold_i;

    always_comb begin
        unique case (order_i)
            SCAN_COL_MAJOR: begin
                row_step_o = adv;
                col_step_o = adv & row_end_i;
            end
            default: begin
                col_step_o = adv;
                row_step_o = adv & col_end_i;
            end
        endcase
    end

endmodule

// File: rtl/win_addr_seq.sv
module win_addr_seq
    import win_addr_seq_pkg::*;
#(
    parameter int unsigned NCOLS  = 64,
    parameter int unsigned NROWS  = 80,
    parameter int unsigned IN_W   = 8,
    parameter int unsigned DATA_W = 8,
    localparam int unsigned COL_AW = ptr_width(NCOLS),
    localparam int unsigned ROW_AW = ptr_width(NROWS),
    localparam int unsigned ADDR_W = ptr_width(NCOLS * NROWS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              col_load,
    input  logic [IN_W-1:0]   col_first,
    input  logic [IN_W-1:0]   col_last,
    input  logic              row_load,
    input  logic [IN_W-1:0]   row_first,
    input  logic [IN_W-1:0]   row_last,
    input  logic              vert_mode,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_byte,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_data
);

    logic [COL_AW-1:0] col_cur;
    logic [ROW_AW-1:0] row_cur;
    logic              col_end, row_end;
    logic              col_step, row_step;
    scan_e             order;

    assign order = vert_mode ? SCAN_COL_MAJOR : SCAN_ROW_MAJOR;

    win_step_ctrl u_step (
        .wr_i       (wr_stb),
        .hold_i     (col_load | row_load),
        .order_i    (order),
        .col_end_i  (col_end),
        .row_end_i  (row_end),
        .col_step_o (col_step),
        .row_step_o (row_step)
    );

    win_axis_ptr #(.N(NCOLS), .IN_W(IN_W)) u_col (
        .clk      (clk),
        .rst      (rst),
        .load_i   (col_load),
        .first_i  (col_first),
        .last_i   (col_last),
        .step_i   (col_step),
        .cur_o    (col_cur),
        .at_end_o (col_end)
    );

    win_axis_ptr #(.N(NROWS), .IN_W(IN_W)) u_row (
        .clk      (clk),
        .rst      (rst),
        .load_i   (row_load),
        .first_i  (row_first),
        .last_i   (row_last),
        .step_i   (row_step),
        .cur_o    (row_cur),
        .at_end_o (row_end)
    );

    // Write goes out at the current position; pointers move on the next edge
    assign mem_we   = wr_stb;
    assign mem_data = wr_byte;
    assign mem_addr = ADDR_W'(col_cur) + ADDR_W'(row_cur) * ADDR_W'(NCOLS);

endmodule

// File: rtl/win_addr_seq_chk.sv
module win_addr_seq_chk
    import win_addr_seq_pkg::*;
#(
    parameter int unsigned NCOLS  = 64,
    parameter int unsigned NROWS  = 80,
    parameter int unsigned IN_W   = 8,
    parameter int unsigned COL_AW = 6,
    parameter int unsigned ROW_AW = 7,
    parameter int unsigned ADDR_W = 13
) (
    input logic              clk,
    input logic              rst,
    input logic              col_load,
    input logic [IN_W-1:0]   col_first,
    input logic              row_load,
    input logic [IN_W-1:0]   row_first,
    input logic              vert_mode,
    input logic              wr_stb,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [COL_AW-1:0] col_cur,
    input logic [ROW_AW-1:0] row_cur
);

    a_r1_reset_origin: assert property (@(posedge clk)
        rst |=> (col_cur == '0 && row_cur == '0));

    a_r2_addr_in_range: assert property (@(posedge clk) disable iff (rst)
        32'(mem_addr) < NCOLS * NROWS);

    // R3/R4: horizontal write either bumps the column alone or wraps it back
    a_r3_horz_step: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && !vert_mode && !col_load && !row_load) |=>
        ((col_cur == $past(col_cur) + COL_AW'(1) && row_cur == $past(row_cur))
         || (col_cur <= $past(col_cur))));

    // R6/R7: vertical write either bumps the row alone or wraps it back
    a_r6_vert_step: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && vert_mode && !col_load && !row_load) |=>
        ((row_cur == $past(row_cur) + ROW_AW'(1) && col_cur == $past(col_cur))
         || (row_cur <= $past(row_cur))));

    a_r8_col_load: assert property (@(posedge clk) disable iff (rst)
        col_load |=> col_cur == COL_AW'(fold_mod(32'($past(col_first)), NCOLS)));

    a_r9_row_load: assert property (@(posedge clk) disable iff (rst)
        row_load |=> row_cur == ROW_AW'(fold_mod(32'($past(row_first)), NROWS)));

    a_r10_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!wr_stb && !col_load && !row_load) |=> ($stable(col_cur) && $stable(row_cur)));

    // R11: a load wins over the advance of the other axis
    a_r11_load_freezes_row: assert property (@(posedge clk) disable iff (rst)
        (col_load && !row_load) |=> $stable(row_cur));

endmodule

bind win_addr_seq win_addr_seq_chk #(
    .NCOLS (NCOLS),
    .NROWS (NROWS),
    .IN_W  (IN_W),
    .COL_AW(COL_AW),
    .ROW_AW(ROW_AW),
    .ADDR_W(ADDR_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .col_load  (col_load),
    .col_first (col_first),
    .row_load  (row_load),
    .row_first (row_first),
    .vert_mode (vert_mode),
    .wr_stb    (wr_stb),
    .mem_addr  (mem_addr),
    .col_cur   (col_cur),
    .row_cur   (row_cur)
);

// File: tb/win_addr_seq_bench.sv
`timescale 1ns/1ps
module win_addr_seq_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        col_load = 1'b0, row_load = 1'b0;
    logic [7:0]  col_first = '0, col_last = '0, row_first = '0, row_last = '0;
    logic        vert_mode = 1'b0;
    logic        wr_stb = 1'b0;
    logic [7:0]  wr_byte = '0;
    logic        mem_we;
    logic [12:0] mem_addr;
    logic [7:0]  mem_data;

    int n_checks = 0;
    int n_fails  = 0;

    always #2.5 clk = ~clk;

    win_addr_seq u_win_addr_seq (
        .clk(clk), .rst(rst),
        .col_load(col_load), .col_first(col_first), .col_last(col_last),
        .row_load(row_load), .row_first(row_first), .row_last(row_last),
        .vert_mode(vert_mode), .wr_stb(wr_stb), .wr_byte(wr_byte),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_data(mem_data)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic set_cols(input int f, input int l);
        @(negedge clk);
        col_load = 1'b1; col_first = f[7:0]; col_last = l[7:0];
        @(negedge clk);
        col_load = 1'b0;
    endtask

    task automatic set_rows(input int f, input int l);
        @(negedge clk);
        row_load = 1'b1; row_first = f[7:0]; row_last = l[7:0];
        @(negedge clk);
        row_load = 1'b0;
    endtask

    // One pixel byte; expected position from the requirement formula
    task automatic wr_exp(input int d, input int ecol, input int erow, input string tag);
        int ea;
        ea = ecol + erow * 64;
        @(negedge clk);
        wr_stb = 1'b1; wr_byte = d[7:0];
        #1;
        chk(mem_addr == 13'(ea), tag, int'(mem_addr), ea);
        chk(mem_we == 1'b1, "R2 we", int'(mem_we), 1);
        chk(mem_data == d[7:0], "R2 data", int'(mem_data), d);
        @(posedge clk);
        #1 wr_stb = 1'b0;
    endtask

    task automatic t_reset;
        @(negedge clk);
        #1;
        chk(mem_we == 1'b0, "R1 idle we", int'(mem_we), 0);
        chk(mem_addr == '0, "R1 origin", int'(mem_addr), 0);
        wr_exp(8'hA5, 0, 0, "R2 first write");
        wr_exp(8'h3C, 1, 0, "R3 column step");
        // full-width window after reset: row changes only at col 63
        for (int c = 2; c < 64; c++) wr_exp(c, c, 0, "R1 full width");
        wr_exp(8'h11, 0, 1, "R4 full-width wrap");
    endtask

    task automatic t_horz_window;
        vert_mode = 1'b0;
        set_cols(2, 4);
        set_rows(5, 6);
        for (int r = 5; r <= 6; r++)
            for (int c = 2; c <= 4; c++)
                wr_exp(c * 16 + r, c, r, (c == 2 && r == 6) ? "R4 col wrap" : "R3 horz");
        wr_exp(8'h77, 2, 5, "R5 row wrap");
    endtask

    task automatic t_far_corner;
        set_cols(62, 63);
        set_rows(78, 79);
        wr_exp(1, 62, 78, "R3 corner");
        wr_exp(2, 63, 78, "R3 corner");
        wr_exp(3, 62, 79, "R4 corner");
        wr_exp(4, 63, 79, "R2 last cell");
        wr_exp(5, 62, 78, "R5 corner wrap");
    endtask

    task automatic t_vert_window;
        set_cols(1, 2);
        set_rows(3, 5);
        @(negedge clk) vert_mode = 1'b1;
        for (int c = 1; c <= 2; c++)
            for (int r = 3; r <= 5; r++)
                wr_exp(r + c, c, r, (r == 3 && c == 2) ? "R6 row wrap" : "R6 vert");
        wr_exp(8'h99, 1, 3, "R7 col wrap");
        @(negedge clk) vert_mode = 1'b0;
    endtask

    task automatic t_fold_loads;
        set_cols(70, 200);   // -> 6 .. 8
        set_rows(165, 87);   // -> 5 .. 7
        wr_exp(1, 6, 5, "R8/R9 folded start");
        wr_exp(2, 7, 5, "R8 folded");
        wr_exp(3, 8, 5, "R8 folded end");
        wr_exp(4, 6, 6, "R9 folded");
        wr_exp(5, 7, 6, "R9 folded");
    endtask

    task automatic t_idle_hold;
        repeat (6) @(negedge clk);
        wr_exp(6, 8, 6, "R10 hold");
        repeat (3) @(negedge clk);
        wr_exp(7, 6, 7, "R10 hold");
    endtask

    task automatic t_load_with_write;
        // current position (7,7); column load coincides with a write
        @(negedge clk);
        wr_stb = 1'b1; wr_byte = 8'h5A;
        col_load = 1'b1; col_first = 8'd20; col_last = 8'd21;
        #1;
        chk(mem_addr == 13'(7 + 7 * 64), "R11 old address", int'(mem_addr), 7 + 7 * 64);
        @(posedge clk);
        #1 begin wr_stb = 1'b0; col_load = 1'b0; end
        wr_exp(8, 20, 7, "R11 no advance");
        wr_exp(9, 21, 7, "R11 new window");
    endtask

    task automatic t_reversed;
        set_cols(10, 5);
        set_rows(0, 2);
        wr_exp(1, 10, 0, "R12 reversed");
        wr_exp(2, 10, 1, "R12 reversed");
        wr_exp(3, 10, 2, "R12 reversed");
        wr_exp(4, 10, 0, "R12 reversed");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_horz_window();
        t_far_corner();
        t_vert_window();
        t_fold_loads();
        t_idle_hold();
        t_load_with_write();
        t_reversed();
        repeat (2) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        #100000;
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule